// File: doc/BRIEF.md
# Banked Pin I/O Controller with Single-Pin Byte Registers

The controller manages a set of general-purpose pins grouped into ports (by default 8 ports of 32 pins, 256 pins in all). Every pin has a private byte-wide value register in the low part of the address map. Software can drive or sample one pin with a single access, with no read-modify-write of a shared word. Each port also has a 32-bit direction word higher in the map. A set bit in that word enables the pad driver of the matching pin.

The pad side has three flat vectors. `pad_out` carries the output latches and `pad_oe` carries the direction bits. `pad_in` is sampled through a two-stage synchronizer before the bus can read it. A bus read of a pin returns the latch when the pin is an output and the synchronized pad level when it is an input. The bus is a simple single-cycle select/write port with a registered read result. An asynchronous active-low reset is released to the logic through a two-flop synchronizer.

Top module: `pin_bank_ctrl`

## Requirements
- R1: For as long as reset is held, and for the first read after it is released, every output latch is 0, every direction bit is 0, `pad_out` and `pad_oe` are all zero, and reads of any pin return 0.
- R2: Pin n is bit n of the pad vectors, where n = port × 32 + bit. Its value register is at byte offset n, for offsets 0x000 to 0x0FF.
- R3: A write to a pin offset sets that pin's latch to 1 when `bus_wdata[7:0]` is nonzero and to 0 when it is zero. The new value is on `pad_out` from the clock edge that takes the write. No other latch changes.
- R4: A read is answered on `bus_rdata` in the cycle after the edge that takes it. A pin read returns exactly 0x00000000 or 0x00000001.
- R5: A read of a pin whose direction bit is 0 returns the pad level that was present two clock edges before the edge that takes the read.
- R6: A read of a pin whose direction bit is 1 returns that pin's output latch.
- R7: The direction word for port p is at offset 0x2000 + 4 × p, for word-aligned offsets only. A write stores all 32 bits, bit b drives `pad_oe[p×32+b]` from the next edge, and a read returns the stored word.
- R8: A pin's latch can be written while the pin is an input. The value is on `pad_out` at once, and it is driven out when the direction bit is later set.
- R9: Reads of any other offset return 0. This covers 0x100–0x1FFF, non-aligned offsets in the direction window, and offsets past the last port. Writes to such offsets change neither `pad_out` nor `pad_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 14 | Byte offset from the block base |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read result, valid the cycle after the request |
| pad_in | input | 256 | Pad input levels |
| pad_out | output | 256 | Output latch values |
| pad_oe | output | 256 | Output enables (direction bits) |

## Verification
Write effects on `pad_out` and `pad_oe` are due right after the edge that takes the write, so the bench samples them at the following falling edge. Read data sits one register behind the request and is sampled at the falling edge after the edge that takes the read. An input change shows up only in a read taken two edges after the change. The bench changes a pad and then issues three back-to-back reads, expecting 0, 0, 1. In the random phase it holds `pad_in` for three cycles before any read.

// File: rtl/pin_bank_pkg.sv
package pin_bank_pkg;
  localparam int unsigned DATA_W = 32;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_PIN  = 2'd1,
    ACC_DIR  = 2'd2
  } acc_kind_t;
endpackage

// File: rtl/pin_bank_dec.sv
module pin_bank_dec
  import pin_bank_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 8,
  parameter int unsigned PORT_W    = 32,
  parameter int unsigned ADDR_W    = 14,
  parameter int unsigned DIR_BASE  = 32'h2000
) (
  input  logic                         sel,
  input  logic [ADDR_W-1:0]            addr,
  output acc_kind_t                    kind,
  output logic [$clog2(NUM_PORTS*PORT_W)-1:0] pin_idx,
  output logic [$clog2(NUM_PORTS)-1:0] port_idx
);
  localparam int unsigned NUM_PINS = NUM_PORTS * PORT_W;
  localparam int unsigned PIN_W    = $clog2(NUM_PINS);
  localparam int unsigned PRT_W    = $clog2(NUM_PORTS);
  localparam int unsigned DIR_END  = DIR_BASE + 4 * NUM_PORTS;

  logic [31:0] addr_ext;
  logic [31:0] dir_off;

  always_comb begin
    addr_ext = 32'(addr);
    dir_off  = addr_ext - DIR_BASE;
    kind     = ACC_NONE;
    pin_idx  = addr[PIN_W-1:0];
    port_idx = dir_off[PRT_W+1:2];
    if (sel) begin
      if (addr_ext < NUM_PINS) begin
        kind = ACC_PIN;
      end else if (addr_ext >= DIR_BASE && addr_ext < DIR_END &&
                   addr[1:0] == 2'b00) begin
        kind = ACC_DIR;
      end
    end
  end
endmodule

// File: rtl/pin_bank_sync.sv
module pin_bank_sync #(
  parameter int unsigned W = 256
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      q        <= '0;
    end else begin
      stage1_q <= d;
      q        <= stage1_q;
    end
  end
endmodule

// File: rtl/pin_bank_port.sv
module pin_bank_port #(
  parameter int unsigned PORT_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      pin_we,
  input  logic [$clog2(PORT_W)-1:0] pin_bit,
  input  logic                      pin_val,
  input  logic                      dir_we,
  input  logic [PORT_W-1:0]         dir_wdata,
  output logic [PORT_W-1:0]         out_q,
  output logic [PORT_W-1:0]         dir_q
);
  logic [PORT_W-1:0] out_d;
  logic              out_en;

  always_comb begin
    out_d          = out_q;
    out_d[pin_bit] = pin_val;
    out_en         = pin_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
    end else if (out_en) begin
      out_q <= out_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
    end else if (dir_we) begin
      dir_q <= dir_wdata;
    end
  end
endmodule

// File: rtl/pin_bank_ctrl.sv
module pin_bank_ctrl
  import pin_bank_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 8,
  parameter int unsigned PORT_W    = 32,
  parameter int unsigned ADDR_W    = 14,
  parameter int unsigned DIR_BASE  = 32'h2000
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_sel,
  input  logic                        bus_wr,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [31:0]                 bus_wdata,
  output logic [31:0]                 bus_rdata,
  input  logic [NUM_PORTS*PORT_W-1:0] pad_in,
  output logic [NUM_PORTS*PORT_W-1:0] pad_out,
  output logic [NUM_PORTS*PORT_W-1:0] pad_oe
);
  localparam int unsigned NUM_PINS = NUM_PORTS * PORT_W;
  localparam int unsigned PIN_W    = $clog2(NUM_PINS);
  localparam int unsigned PRT_W    = $clog2(NUM_PORTS);
  localparam int unsigned BIT_W    = $clog2(PORT_W);

  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  acc_kind_t        kind;
  logic [PIN_W-1:0] pin_idx;
  logic [PRT_W-1:0] port_idx;

  pin_bank_dec #(
    .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W),
    .ADDR_W(ADDR_W), .DIR_BASE(DIR_BASE)
  ) i_dec (
    .sel(bus_sel), .addr(bus_addr), .kind(kind),
    .pin_idx(pin_idx), .port_idx(port_idx)
  );

  logic [NUM_PINS-1:0] in_sync;

  pin_bank_sync #(.W(NUM_PINS)) i_sync (
    .clk(clk), .rst_n(rst_sync_n), .d(pad_in), .q(in_sync)
  );

  logic              pin_write, dir_write, wr_level;
  logic [PRT_W-1:0]  pin_port;
  logic [BIT_W-1:0]  pin_bit;
  logic [PORT_W-1:0] dir_words [NUM_PORTS];

  always_comb begin
    pin_write = (kind == ACC_PIN) && bus_wr;
    dir_write = (kind == ACC_DIR) && bus_wr;
    wr_level  = |bus_wdata[7:0];
    pin_port  = pin_idx[PIN_W-1:BIT_W];
    pin_bit   = pin_idx[BIT_W-1:0];
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [PORT_W-1:0] out_w, dir_w;

    pin_bank_port #(.PORT_W(PORT_W)) i_port (
      .clk(clk), .rst_n(rst_sync_n),
      .pin_we(pin_write && (pin_port == PRT_W'(p))),
      .pin_bit(pin_bit), .pin_val(wr_level),
      .dir_we(dir_write && (port_idx == PRT_W'(p))),
      .dir_wdata(bus_wdata[PORT_W-1:0]),
      .out_q(out_w), .dir_q(dir_w)
    );

    assign pad_out[p*PORT_W +: PORT_W] = out_w;
    assign pad_oe[p*PORT_W +: PORT_W]  = dir_w;
    assign dir_words[p]                = dir_w;
  end

  logic [31:0] rdata_d;
  logic        rd_pin_level;

  always_comb begin
    rd_pin_level = pad_oe[pin_idx] ? pad_out[pin_idx] : in_sync[pin_idx];
    rdata_d      = '0;
    if (!bus_wr) begin
      unique case (kind)
        ACC_PIN:  rdata_d = {31'b0, rd_pin_level};
        ACC_DIR:  rdata_d = 32'(dir_words[port_idx]);
        default:  rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      bus_rdata <= '0;
    end else begin
      bus_rdata <= rdata_d;
    end
  end
endmodule

// File: rtl/pin_bank_chk.sv
module pin_bank_chk #(
  parameter int unsigned NUM_PORTS = 8,
  parameter int unsigned PORT_W    = 32,
  parameter int unsigned ADDR_W    = 14,
  parameter int unsigned DIR_BASE  = 32'h2000
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        bus_sel,
  input logic                        bus_wr,
  input logic [ADDR_W-1:0]           bus_addr,
  input logic [31:0]                 bus_wdata,
  input logic [31:0]                 bus_rdata,
  input logic [NUM_PORTS*PORT_W-1:0] pad_out,
  input logic [NUM_PORTS*PORT_W-1:0] pad_oe
);
  localparam int unsigned NUM_PINS = NUM_PORTS * PORT_W;
  localparam int unsigned PIN_W    = $clog2(NUM_PINS);

  logic is_pin, is_dir0, is_unmapped;
  always_comb begin
    is_pin      = 32'(bus_addr) < NUM_PINS;
    is_dir0     = 32'(bus_addr) == DIR_BASE;
    is_unmapped = !is_pin &&
                  (32'(bus_addr) < DIR_BASE ||
                   32'(bus_addr) >= DIR_BASE + 4 * NUM_PORTS ||
                   bus_addr[1:0] != 2'b00);
  end

  // R3
  pin_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && is_pin) |=>
      pad_out[$past(bus_addr[PIN_W-1:0])] == $past(|bus_wdata[7:0]));

  // R9
  idle_keeps_pads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr) |=> ($stable(pad_out) && $stable(pad_oe)));

  // R4
  pin_read_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && is_pin) |=> bus_rdata[31:1] == 31'b0);

  // R9
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && is_unmapped) |=> bus_rdata == 32'b0);

  // R7
  dir_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && is_dir0) |=>
      pad_oe[PORT_W-1:0] == $past(bus_wdata[PORT_W-1:0]));
endmodule

bind pin_bank_ctrl pin_bank_chk #(
  .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W),
  .ADDR_W(ADDR_W), .DIR_BASE(DIR_BASE)
) i_pin_bank_chk (
  .clk(clk), .rst_n(rst_sync_n),
  .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/test_pin_bank_ctrl.sv
`timescale 1ns/1ps
module test_pin_bank_ctrl;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         bus_sel, bus_wr;
  logic [13:0]  bus_addr;
  logic [31:0]  bus_wdata, bus_rdata;
  logic [255:0] pad_in, pad_out, pad_oe;
  logic [255:0] exp_out, exp_oe;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pin_bank_ctrl i_pin_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic check(string req, logic [255:0] act, logic [255:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit is_pin(int a); return a < 256; endfunction
  function automatic bit is_dir(int a);
    return a >= 'h2000 && a < 'h2020 && (a % 4) == 0;
  endfunction

  function automatic logic [31:0] exp_read(int a);
    if (is_pin(a)) return {31'b0, exp_oe[a] ? exp_out[a] : pad_in[a]};
    if (is_dir(a)) return exp_oe[(a - 'h2000) / 4 * 32 +: 32];
    return 32'b0;
  endfunction

  task automatic bus_write(int a, logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = 14'(a); bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    if (is_pin(a)) exp_out[a] = |d[7:0];
    else if (is_dir(a)) exp_oe[(a - 'h2000) / 4 * 32 +: 32] = d;
  endtask

  task automatic bus_read(int a, output logic [31:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = 14'(a); bus_wdata = $urandom;
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  task automatic read_check(string req, int a);
    logic [31:0] d;
    logic [31:0] e;
    e = exp_read(a);
    bus_read(a, d);
    check(req, 256'(d), 256'(e));
  endtask

  task automatic pads_check(string req);
    check({req, " pad_out"}, pad_out, exp_out);
    check({req, " pad_oe"}, pad_oe, exp_oe);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h1b2c));
    rst_n = 0; bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    pad_in = '0; exp_out = '0; exp_oe = '0;
    repeat (3) @(negedge clk);
    // R1: pads idle during reset
    pads_check("R1 in-reset");
    rst_n = 1;
    repeat (4) @(negedge clk);
    pads_check("R1 after-reset");
    read_check("R1 pin read", 5);

    // R3/R8: write latch while input, then enable
    bus_write(37, 32'hA5);
    pads_check("R3 R8 write-while-input");
    read_check("R5 input read ignores latch", 37);
    bus_write('h2004, 32'h0000_0020);
    pads_check("R7 R8 enable port1 bit5");
    read_check("R6 output read", 37);
    bus_write(37, 32'h0000_FF00);
    pads_check("R3 zero low byte");
    read_check("R6 output read low", 37);
    bus_write(37, 32'h80);
    pads_check("R3 bit7 nonzero");

    // R5: synchronizer latency
    pad_in[200] = 1'b1;
    bus_read(200, d); check("R5 latency edge1", 256'(d), 256'(0));
    bus_read(200, d); check("R5 latency edge2", 256'(d), 256'(0));
    bus_read(200, d); check("R4 R5 latency edge3", 256'(d), 256'(1));

    // R2: last pin mapping
    bus_write(255, 32'h1);
    bus_write('h201C, 32'h8000_0000);
    pads_check("R2 R7 pin255");
    read_check("R7 dir readback", 'h201C);
    read_check("R7 dir readback p1", 'h2004);

    // R9: unmapped offsets
    bus_write('h100, 32'hFFFF_FFFF);
    bus_write('h2005, 32'hFFFF_FFFF);
    bus_write('h2020, 32'hFFFF_FFFF);
    bus_write('h1FFC, 32'hFFFF_FFFF);
    pads_check("R9 unmapped writes");
    read_check("R9 read 0x100", 'h100);
    read_check("R9 read 0x2005", 'h2005);
    read_check("R9 read 0x2020", 'h2020);

    // random phase
    pad_in = {$urandom, $urandom, $urandom, $urandom,
              $urandom, $urandom, $urandom, $urandom};
    repeat (3) @(negedge clk);
    for (int i = 0; i < 600; i++) begin
      int sel = $urandom_range(0, 9);
      int a;
      if (sel < 4) begin
        a = $urandom_range(0, 255);
        bus_write(a, ($urandom_range(0, 1) != 0) ? 32'($urandom_range(0, 255)) : 32'h0);
        pads_check("R3 random write");
      end else if (sel == 4) begin
        a = 'h2000 + 4 * $urandom_range(0, 7);
        bus_write(a, $urandom);
        pads_check("R7 random dir");
      end else if (sel < 9) begin
        a = $urandom_range(0, 255);
        read_check("R5 R6 random pin read", a);
      end else begin
        a = $urandom_range(0, 'h3FFF);
        read_check("R9 R7 random any read", a);
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule